// File: doc/BRIEF.md
# Full-Frame CCD Clock Sequencer

This block produces the digital timing for a full-frame CCD that has two vertical phases and two horizontal phases. It runs from a single system clock and divides it into pixel periods. From those periods it derives the vertical transfer phases, the horizontal shift phases and the reset-gate pulse. It also produces the clamp and sample strobes for the video ADC, and a marker at the start of each line and at the start of each frame. Analog level translation and the clock drivers sit outside this block.

One exposure has two parts. After a start request the sequencer integrates for a programmed number of pixel periods, with both vertical phases held low. It then reads out the programmed number of lines. Each line is read in three steps. First comes a vertical transfer: the first vertical phase is pulsed, then the second. Next comes a horizontal setup gap. Last, the horizontal register is shifted once for every pixel of the line. During the vertical transfer and the setup gap, the first horizontal phase is held high, so charge enters the horizontal register when the second vertical phase falls. The reset gate pulses in every pixel period, in every state. An abort request returns the sequencer to idle at the next pixel boundary.

All state changes happen at pixel boundaries. Within a pixel period, tick 0 is the first system clock of the period. Every duration is a parameter, counted in pixel periods. The defaults give a 10-tick pixel (250 ns at 40 MHz), 80-period vertical pulses (20 µs), a 32-period setup gap (8 µs) and a frame of 3086 lines with 3103 pixels each.

Top module: `ccd_clock_seq`

## Requirements
- R1: While reset is asserted and in idle, both vertical phases are 0, the first horizontal phase is 1, the second horizontal phase is 0, and the clamp, sample, line-marker and frame-marker outputs are 0.
- R2: Outside reset, the reset-gate output is 1 during tick 0 of every pixel period and 0 on every other tick, whatever the sequencer state.
- R3: In idle, a start input seen high on the last tick of a pixel period moves the sequencer into integration from the next pixel period. A start input seen in any other state is ignored.
- R4: Integration lasts int_pix+1 pixel periods, with both vertical phases at 0. The value of int_pix is captured at the start request, and later changes to int_pix have no effect on the running exposure.
- R5: Each line transfer drives the first vertical phase to 1 for VPULSE_PIX pixel periods, then the second vertical phase to 1 for VPULSE_PIX pixel periods. The two vertical phases are never 1 at the same time.
- R6: In every state except horizontal shifting, the first horizontal phase is 1 and the second is 0. This holds in particular from the start of the first vertical pulse until the setup gap of HSETUP_PIX pixel periods ends, and at the falling edge of the second vertical phase.
- R7: During shifting, the first horizontal phase is 1 on ticks 0 to TPP/2-1 and the second horizontal phase is 1 on the remaining ticks. There are PIX_PER_LINE such pixel periods per line.
- R8: The clamp strobe is 1 on tick CLAMP_TICK (default 3) and the sample strobe is 1 on tick SAMPLE_TICK (default 8), only in pixel periods of horizontal shifting.
- R9: The line marker is 1 for one tick, at tick 0 of the first shift pixel period of each line. The frame marker is 1 together with the line marker, for the first line of a frame only.
- R10: After LINES lines, the sequencer spends one pixel period in a done state with the idle output levels, then returns to idle.
- R11: An abort input seen high on the last tick of a pixel period returns the sequencer to idle from the next pixel period, with both vertical phases at 0. The next readout then starts again from its first line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one tick) |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Exposure start request, sampled on the last tick of a pixel period |
| abort | input | 1 | Return-to-idle request, sampled on the last tick of a pixel period |
| int_pix | input | INT_W | Integration length minus one, in pixel periods |
| vphase1 | output | 1 | First vertical transfer phase |
| vphase2 | output | 1 | Second vertical transfer phase |
| hphase1 | output | 1 | First horizontal shift phase |
| hphase2 | output | 1 | Second horizontal shift phase |
| rgate | output | 1 | Reset-gate pulse, one tick per pixel period |
| clamp_stb | output | 1 | ADC clamp strobe |
| sample_stb | output | 1 | ADC sample strobe |
| line_mark | output | 1 | First shift tick of each line |
| frame_mark | output | 1 | First shift tick of the first line of a frame |

## Verification
The bench drives start requests in two places: one at an exact pixel boundary, and one inside a running exposure that must be ignored. A design that sampled start on any tick would begin early or start again. A design that did not ignore start would stretch or restart the exposure. The integration length is changed in the middle of an integration. A design that did not capture it would lengthen the exposure and shift every later edge. An abort during shifting and an abort during integration show whether the sequencer stops at the correct boundary and whether the line count is cleared. A stale count would move the frame marker away from the first line. The bench also counts line and frame markers over a full frame, so a line-count limit that is off by one is caught as an extra or missing line.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_INTEG  = 3'd1,
    ST_VXFER  = 3'd2,
    ST_HSETUP = 3'd3,
    ST_HSHIFT = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_t;

  // true while a tick lies in the first half of a pixel period
  function automatic logic in_first_half(input int unsigned t, input int unsigned per);
    return t < (per / 2);
  endfunction

  // true when a pixel-count lies inside the first vertical pulse
  function automatic logic in_first_vpulse(input int unsigned c, input int unsigned vpix);
    return c < vpix;
  endfunction

endpackage

// File: rtl/ccdseq_pixel_timer.sv
module ccdseq_pixel_timer #(
  parameter int TPP = 10,
  localparam int TW = (TPP > 1) ? $clog2(TPP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tick,
  output logic          pix_last
);
  localparam logic [TW-1:0] LAST = TW'(TPP - 1);

  assign pix_last = (tick == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tick <= '0;
    else if (pix_last) tick <= '0;
    else               tick <= tick + 1'b1;
  end

  // R2
  rg_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_last |=> (tick == '0));
endmodule

// File: rtl/ccdseq_fsm.sv
module ccdseq_fsm import ccdseq_pkg::*; #(
  parameter int INT_W        = 24,
  parameter int LINES        = 3086,
  parameter int PIX_PER_LINE = 3103,
  parameter int VPULSE_PIX   = 80,
  parameter int HSETUP_PIX   = 32,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [INT_W-1:0] int_pix,
  input  logic             pix_last,
  output seq_state_t       state,
  output logic [INT_W-1:0] cnt,
  output logic [LW-1:0]    line
);
  localparam logic [INT_W-1:0] VX_LAST = INT_W'(2 * VPULSE_PIX - 1);
  localparam logic [INT_W-1:0] HS_LAST = INT_W'(HSETUP_PIX - 1);
  localparam logic [INT_W-1:0] PX_LAST = INT_W'(PIX_PER_LINE - 1);
  localparam logic [LW-1:0]    LN_LAST = LW'(LINES - 1);

  logic [INT_W-1:0] int_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      line  <= '0;
      int_q <= '0;
    end else if (pix_last) begin
      if (abort) begin
        state <= ST_IDLE;
        cnt   <= '0;
        line  <= '0;
      end else begin
        unique case (state)
          ST_IDLE: if (start) begin
            state <= ST_INTEG;
            int_q <= int_pix;
            cnt   <= '0;
          end
          ST_INTEG: begin
            if (cnt == int_q) begin
              state <= ST_VXFER;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_VXFER: begin
            if (cnt == VX_LAST) begin
              state <= ST_HSETUP;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_HSETUP: begin
            if (cnt == HS_LAST) begin
              state <= ST_HSHIFT;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_HSHIFT: begin
            if (cnt == PX_LAST) begin
              cnt <= '0;
              if (line == LN_LAST) begin
                state <= ST_DONE;
                line  <= '0;
              end else begin
                state <= ST_VXFER;
                line  <= line + 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          end
          ST_DONE: begin
            state <= ST_IDLE;
            cnt   <= '0;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && pix_last) |=> (state == ST_IDLE));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && pix_last) |=> (state == ST_IDLE));

  // R3
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_last) |=> $stable(state));
endmodule

// File: rtl/ccdseq_phase_gen.sv
module ccdseq_phase_gen import ccdseq_pkg::*; #(
  parameter int TPP         = 10,
  parameter int INT_W       = 24,
  parameter int LW          = 12,
  parameter int VPULSE_PIX  = 80,
  parameter int CLAMP_TICK  = 3,
  parameter int SAMPLE_TICK = 8,
  localparam int TW = (TPP > 1) ? $clog2(TPP) : 1
) (
  input  seq_state_t       state,
  input  logic [INT_W-1:0] cnt,
  input  logic [LW-1:0]    line,
  input  logic [TW-1:0]    tick,
  output logic             vphase1,
  output logic             vphase2,
  output logic             hphase1,
  output logic             hphase2,
  output logic             rgate,
  output logic             clamp_stb,
  output logic             sample_stb,
  output logic             line_mark,
  output logic             frame_mark
);
  logic shifting, xfer, early;

  assign shifting = (state == ST_HSHIFT);
  assign xfer     = (state == ST_VXFER);
  assign early    = in_first_vpulse(32'(cnt), VPULSE_PIX);

  assign vphase1 = xfer && early;
  assign vphase2 = xfer && !early;

  assign hphase1 = !shifting || in_first_half(32'(tick), TPP);
  assign hphase2 = shifting && !in_first_half(32'(tick), TPP);

  assign rgate      = (tick == '0);
  assign clamp_stb  = shifting && (tick == TW'(CLAMP_TICK));
  assign sample_stb = shifting && (tick == TW'(SAMPLE_TICK));

  assign line_mark  = shifting && (cnt == '0) && (tick == '0);
  assign frame_mark = line_mark && (line == '0);
endmodule

// File: rtl/ccd_clock_seq.sv
module ccd_clock_seq import ccdseq_pkg::*; #(
  parameter int TPP          = 10,
  parameter int INT_W        = 24,
  parameter int LINES        = 3086,
  parameter int PIX_PER_LINE = 3103,
  parameter int VPULSE_PIX   = 80,
  parameter int HSETUP_PIX   = 32,
  parameter int CLAMP_TICK   = 3,
  parameter int SAMPLE_TICK  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [INT_W-1:0] int_pix,
  output logic             vphase1,
  output logic             vphase2,
  output logic             hphase1,
  output logic             hphase2,
  output logic             rgate,
  output logic             clamp_stb,
  output logic             sample_stb,
  output logic             line_mark,
  output logic             frame_mark
);
  localparam int TW = (TPP > 1) ? $clog2(TPP) : 1;
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;

  logic [TW-1:0]    tick;
  logic             pix_last;
  seq_state_t       state;
  logic [INT_W-1:0] cnt;
  logic [LW-1:0]    line;

  ccdseq_pixel_timer #(.TPP(TPP)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pix_last(pix_last));

  ccdseq_fsm #(
    .INT_W(INT_W), .LINES(LINES), .PIX_PER_LINE(PIX_PER_LINE),
    .VPULSE_PIX(VPULSE_PIX), .HSETUP_PIX(HSETUP_PIX)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .int_pix(int_pix), .pix_last(pix_last),
    .state(state), .cnt(cnt), .line(line));

  ccdseq_phase_gen #(
    .TPP(TPP), .INT_W(INT_W), .LW(LW), .VPULSE_PIX(VPULSE_PIX),
    .CLAMP_TICK(CLAMP_TICK), .SAMPLE_TICK(SAMPLE_TICK)
  ) u_phase (
    .state(state), .cnt(cnt), .line(line), .tick(tick),
    .vphase1(vphase1), .vphase2(vphase2), .hphase1(hphase1), .hphase2(hphase2),
    .rgate(rgate), .clamp_stb(clamp_stb), .sample_stb(sample_stb),
    .line_mark(line_mark), .frame_mark(frame_mark));

  // R5
  v_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vphase1 && vphase2));

  // R6
  hload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vphase2) |-> (hphase1 && !hphase2));

  // R2
  rg_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgate |=> !rgate);

  // R9
  frame_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |-> (line_mark && hphase1));

  // R8
  strobe_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_stb || sample_stb) |-> !(vphase1 || vphase2));
endmodule

// File: tb/ccd_clock_seq_test.sv
module ccd_clock_seq_test;
  localparam int TPP = 10, INT_W = 8, LINES = 3, PIX = 12, VP = 4, HS = 3;
  localparam int CT = 3, ST = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic [INT_W-1:0] int_pix = '0;
  logic v1, v2, h1, h2, rg, cl, sa, lm, fm;

  int checks = 0, errors = 0, cycles = 0;
  int m_tick = 0, m_mode = 0, m_el = 0, m_line = 0, m_int = 0;
  int n_lm = 0, n_fm = 0;
  bit done_run = 0;

  always #5 clk = ~clk;

  ccd_clock_seq #(.TPP(TPP), .INT_W(INT_W), .LINES(LINES), .PIX_PER_LINE(PIX),
    .VPULSE_PIX(VP), .HSETUP_PIX(HS), .CLAMP_TICK(CT), .SAMPLE_TICK(ST)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .int_pix(int_pix),
    .vphase1(v1), .vphase2(v2), .hphase1(h1), .hphase2(h2), .rgate(rg),
    .clamp_stb(cl), .sample_stb(sa), .line_mark(lm), .frame_mark(fm));

  // reference model: mode 0 idle,1 integrate,2 vertical,3 setup,4 shift,5 done
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_mode = 0; m_el = 0; m_line = 0;
    end else if (m_tick != TPP - 1) begin
      m_tick++;
    end else begin
      m_tick = 0;
      if (abort) begin m_mode = 0; m_el = 0; m_line = 0; end
      else begin
        m_el++;
        case (m_mode)
          0: begin m_el = 0; if (start) begin m_mode = 1; m_int = int'(int_pix); end end
          1: if (m_el > m_int) begin m_mode = 2; m_el = 0; end
          2: if (m_el == 2 * VP) begin m_mode = 3; m_el = 0; end
          3: if (m_el == HS) begin m_mode = 4; m_el = 0; end
          4: if (m_el == PIX) begin
               m_el = 0; m_line++;
               if (m_line == LINES) begin m_mode = 5; m_line = 0; end else m_mode = 2;
             end
          default: begin m_mode = 0; m_el = 0; end
        endcase
      end
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, nm, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done_run) begin
      chk("R2", "rgate", rg, m_tick == 0);
      chk("R5", "vphase1", v1, m_mode == 2 && m_el < VP);
      chk("R5", "vphase2", v2, m_mode == 2 && m_el >= VP);
      chk("R7", "hphase1", h1, m_mode != 4 || m_tick < TPP / 2);
      chk("R6", "hphase2", h2, m_mode == 4 && m_tick >= TPP / 2);
      chk("R8", "clamp", cl, m_mode == 4 && m_tick == CT);
      chk("R8", "sample", sa, m_mode == 4 && m_tick == ST);
      chk("R9", "line_mark", lm, m_mode == 4 && m_el == 0 && m_tick == 0);
      chk("R9", "frame_mark", fm, m_mode == 4 && m_el == 0 && m_tick == 0 && m_line == 0);
      if (lm) n_lm++;
      if (fm) n_fm++;
    end
  end

  task automatic hold_start();
    @(negedge clk); start = 1'b1;
    repeat (TPP) @(negedge clk);
    start = 1'b0;
  endtask

  task automatic hold_abort();
    @(negedge clk); abort = 1'b1;
    repeat (TPP) @(negedge clk);
    abort = 1'b0;
  endtask

  task automatic idle_chk(input string req);
    chk(req, "vphase1", v1, 1'b0); chk(req, "vphase2", v2, 1'b0);
    chk(req, "hphase1", h1, 1'b1); chk(req, "hphase2", h2, 1'b0);
    chk(req, "clamp", cl, 1'b0);   chk(req, "sample", sa, 1'b0);
    chk(req, "line_mark", lm, 1'b0); chk(req, "frame_mark", fm, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1");                         // R1 during reset
    rst_n = 1'b1;
    repeat (25) @(negedge clk);
    idle_chk("R1");                         // R1 idle after reset
    // R3 R4: full frame, start ignored and int_pix changed mid-integration
    n_lm = 0; n_fm = 0;
    int_pix = 8'd5;
    hold_start();
    int_pix = 8'd40;
    hold_start();
    repeat (90 * TPP) @(negedge clk);
    checks++;                               // R9 line count per frame
    if (n_lm != LINES) begin errors++;
      $display("FAIL R9 line markers: actual=%0d expected=%0d", n_lm, LINES); end
    checks++;                               // R9 frame marker once
    if (n_fm != 1) begin errors++;
      $display("FAIL R9 frame markers: actual=%0d expected=1", n_fm); end
    idle_chk("R10");                        // R10 back to idle
    // R11: abort during shifting of the second line
    int_pix = 8'd0;
    hold_start();
    repeat (35 * TPP) @(negedge clk);
    hold_abort();
    repeat (3 * TPP) @(negedge clk);
    idle_chk("R11");
    // R11: next readout restarts at line 0
    n_fm = 0;
    int_pix = 8'd2;
    hold_start();
    repeat (85 * TPP) @(negedge clk);
    checks++;
    if (n_fm != 1) begin errors++;
      $display("FAIL R11 frame marker after abort: actual=%0d expected=1", n_fm); end
    // R11: abort during integration
    int_pix = 8'd30;
    hold_start();
    repeat (5 * TPP) @(negedge clk);
    hold_abort();
    repeat (40 * TPP) @(negedge clk);
    idle_chk("R11");
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule